// File: doc/BRIEF.md
# Token-Ring Round-Robin Bus Arbiter

This block decides which of N bus masters (N is 2 or 4) owns a shared bus. A one-hot token says which master has top priority at the moment. The arbiter holds one fixed-priority slice for each token position. Each slice sees the request vector rotated so that it begins at the slice's own index. Only the slice that the token selects is enabled. The outputs of all slices are mapped back to true master indices and ORed together, which gives a one-hot grant.

The grant is purely combinational from the requests and the token. The token moves to the next master only when the bus owner signals the end of its transfer on the acknowledge input. Priority rotates one step for each acknowledged arbitration, no matter which master was served. So a master that keeps requesting is reached within N acknowledged rounds.

Top module: `tok_rr_arbiter`

## Requirements
- R1: After the active-low synchronous reset, the token sits at master 0, so with every master requesting and no acknowledge the grant is `0001` (bit i of grant belongs to master i).
- R2: With no request bit set, the grant is all zeros.
- R3: At most one grant bit is high in any cycle.
- R4: A grant bit is high only for a master whose request bit is high.
- R5: With the token at master k, requesters are ranked k, k+1, … modulo N, and the grant goes to the first requester in that order. For example, token at 2 with only masters 0 and 1 requesting grants master 0.
- R6: An acknowledge sampled high at a clock edge moves the token one master upward. This holds even when nobody requests, and the new ranking applies from that edge on.
- R7: Without an acknowledge, the token holds its position across clock edges.
- R8: An acknowledge while the token is at master N-1 moves it back to master 0.
- R9: With all masters requesting and an acknowledge every cycle, every master receives a grant within N consecutive acknowledged arbitrations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NUM_MASTERS | Request, one bit per master |
| ack | input | 1 | End of current transfer; advances the token |
| grant | output | NUM_MASTERS | One-hot grant, zero when idle |

## Verification
The grant has no register in its path, so its value for a given request vector is due in the same cycle. The scoreboard drives inputs just after a rising edge and compares at the following falling edge. An acknowledge has its effect one edge later. The reference token in the bench therefore moves only after the expected grant of the acknowledging cycle has been queued, and the next queued item already uses the new ranking. The fairness check collects the grants seen over one run of N acknowledged cycles and requires every master to appear.

// File: rtl/tok_rr_pkg.sv
// Shared helpers for the token-ring arbiter.
// Assumes index arguments lie in 0..n-1.
package tok_rr_pkg;

    // Master index served by position pos of the slice anchored at base
    function automatic int unsigned ring_idx(int unsigned base, int unsigned pos, int unsigned n);
        return (base + pos) % n;
    endfunction

endpackage

// File: rtl/tok_ring.sv
// One-hot token ring. Reset parks the token on bit 0; every acknowledge
// moves it one bit upward, wrapping at the top.
// Assumes N >= 2.
module tok_ring #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [N-1:0] token
);
    localparam logic [N-1:0] HOME = N'(1);

    // Rotate the token on acknowledge, reload it on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            token <= HOME;
        else if (adv)
            token <= {token[N-2:0], token[N-1]};
    end

endmodule

// File: rtl/tok_prio_slice.sv
// Fixed-priority slice: input bit 0 ranks highest. It grants the lowest set
// bit while enabled and drives all zeros while disabled.
// Assumes N >= 1.
module tok_prio_slice #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] in_vec,
    output logic [N-1:0] out_vec
);
    // Pass the first set bit through and block every bit after it
    always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int i = 0; i < N; i++) begin
            out_vec[i] = en & in_vec[i] & ~blocked;
            blocked    = blocked | in_vec[i];
        end
    end

endmodule

// File: rtl/tok_rr_arbiter.sv
// Round-robin bus arbiter. A one-hot token enables one of N fixed-priority
// slices. Each slice sees the requests pre-rotated to its own start index.
// The slice outputs are rotated back and ORed into a one-hot grant.
// Assumes NUM_MASTERS is 2 or 4; the grant is combinational.
module tok_rr_arbiter
    import tok_rr_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   ack,
    output logic [NUM_MASTERS-1:0] grant
);
    localparam int N = NUM_MASTERS;

    logic [N-1:0] token_q;
    logic [N-1:0] rot_req [N];
    logic [N-1:0] sl_out  [N];

    tok_ring #(.N(N)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (ack),
        .token (token_q)
    );

    for (genvar k = 0; k < N; k++) begin : g_slice
        for (genvar j = 0; j < N; j++) begin : g_rot
            assign rot_req[k][j] = req[ring_idx(k, j, N)];
        end

        tok_prio_slice #(.N(N)) u_slice (
            .en      (token_q[k]),
            .in_vec  (rot_req[k]),
            .out_vec (sl_out[k])
        );
    end

    // Map each slice output back to its master and OR all slices together
    always_comb begin
        grant = '0;
        for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++)
                grant[ring_idx(k, j, N)] = grant[ring_idx(k, j, N)] | sl_out[k][j];
    end

endmodule

// File: rtl/tok_rr_checker.sv
// Property checker for tok_rr_arbiter. It is bound to the top module and
// reads the token register through the bind connection.
module tok_rr_checker #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req,
    input logic         ack,
    input logic [N-1:0] grant,
    input logic [N-1:0] token
);
    logic [N-1:0] tok_next;
    assign tok_next = {token[N-2:0], token[N-1]};

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (grant == '0));

    assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_only_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    assert_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> ($countones(grant) == 1));

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (token == $past(tok_next)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> $stable(token));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && token[N-1]) |=> token[0]);

endmodule

bind tok_rr_arbiter tok_rr_checker #(.N(NUM_MASTERS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .ack   (ack),
    .grant (grant),
    .token (token_q)
);

// File: tb/sim_tok_rr_arbiter.sv
// Scoreboard bench: the driver queues expected grants from a reference token
// model, and the monitor compares them at the falling edge.
module sim_tok_rr_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         ack = 1'b0;
    logic [N-1:0] grant;

    int checks = 0;
    int errors = 0;
    int ref_tok = 0;
    bit fair_on = 1'b0;
    logic [N-1:0] served = '0;

    logic [N-1:0] exp_q [$];
    string        tag_q [$];

    always #4 clk = ~clk;

    tok_rr_arbiter #(.NUM_MASTERS(N)) u0 (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .ack   (ack),
        .grant (grant)
    );

    function automatic logic [N-1:0] model(logic [N-1:0] r, int t);
        for (int i = 0; i < N; i++)
            if (r[(t + i) % N]) return N'(1) << ((t + i) % N);
        return '0;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s grant=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one cycle and queue the grant expected in that cycle
    task automatic drive(logic [N-1:0] r, logic a, string tag);
        @(posedge clk);
        #1;
        req = r;
        ack = a;
        exp_q.push_back(model(r, ref_tok));
        tag_q.push_back(tag);
        if (a) ref_tok = (ref_tok + 1) % N;
    endtask

    // Monitor: compare against the queue away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, grant, e);
            if (fair_on) served = served | grant;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        drive(4'b0000, 1'b0, "R2 idle");
        drive(4'b1111, 1'b0, "R1 reset token");
        drive(4'b1010, 1'b0, "R4 skip idle masters");
        drive(4'b1111, 1'b1, "R6 ack cycle");
        drive(4'b1111, 1'b0, "R6 after ack");
        drive(4'b1111, 1'b0, "R7 hold");
        drive(4'b0001, 1'b1, "R5 lone request");
        drive(4'b0011, 1'b0, "R5 token2 low pair");
        drive(4'b1011, 1'b1, "R5 token2 next up");
        drive(4'b0111, 1'b1, "R8 token at top");
        drive(4'b1111, 1'b0, "R8 wrapped");
        drive(4'b0000, 1'b1, "R6 ack while idle");
        drive(4'b0101, 1'b0, "R6 idle ack moved token");
        drive(4'b1100, 1'b0, "R3 two requesters");
        @(negedge clk);
        fair_on = 1'b1;
        served  = '0;
        for (int i = 0; i < N; i++) drive(4'b1111, 1'b1, "R9 rotation");
        @(negedge clk);
        #1 fair_on = 1'b0;
        check("R9 all served", served, 4'b1111);
        drive(4'b0000, 1'b0, "R2 end idle");
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        ref_tok = 0;
        drive(4'b1110, 1'b0, "R1 reset again");
        @(negedge clk);
        #2;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule